// File: doc/BRIEF.md
# Preset-Compare Counter with Interrupt Cause Status

This block is a signed up/down event counter with four programmable compare points: a low preset, a high preset, an upper wrap limit (overflow) and a lower wrap limit (underflow). A count pulse moves the accumulator by one step in the selected direction. Counting past the upper limit wraps the accumulator to the lower limit, and counting past the lower limit wraps it to the upper limit. Landing on a preset is also an event. Each event raises a one-cycle interrupt pulse and records its cause in a four-bit cause field.

The cause bits exclude one another. A new event sets its own bit and clears the other three, so the field always names the latest cause. Software can clear cause bits through a simple write port. Two level flags report live threshold comparisons: "at or below low preset" and "at or above high preset". An executing enable freezes both the counting and the re-evaluation of the level flags.

A four-bit mode selects the feature set. Modes 0 and 1 count up only, and they have no underflow or low-preset features. All other mode values enable every feature.

Top module: `pec_top`

## Requirements
- R1: After reset the accumulator is 0, all cause bits are 0, both level flags are 0 and the interrupt output is 0.
- R2: While `run_en` and `cnt_en` are both 1, each clock adds 1 to the accumulator (when `cnt_up`=1) or subtracts 1 (when `cnt_up`=0), and the new value shows one cycle later. In modes 0 and 1 the count is always upward. If either enable is 0, the accumulator holds its value.
- R3: An up count taken when the accumulator is at or above `ovf_limit` loads `unf_limit` instead of adding 1. It sets cause bit 0 (overflow) and pulses the interrupt.
- R4: In modes 2 to 15, a down count taken when the accumulator is at or below `unf_limit` loads `ovf_limit` instead of subtracting 1. It sets cause bit 1 (underflow) and pulses the interrupt.
- R5: An up count that does not wrap and whose result equals `hi_preset` sets cause bit 2 (high preset) and pulses the interrupt.
- R6: In modes 2 to 15, a down count that does not wrap and whose result equals `lo_preset` sets cause bit 3 (low preset) and pulses the interrupt. An up count onto `lo_preset` raises no event.
- R7: Every event leaves exactly its own cause bit set and clears the other three cause bits.
- R8: A cycle with `wr_en`=1 changes the cause bits to `cause & wr_data`: a 0 clears its bit and a 1 has no effect. If an event occurs in the same cycle, the event's result wins.
- R9: `lo_reached_o` is (accumulator <= `lo_preset`) and `hi_reached_o` is (accumulator >= `hi_preset`), both in signed compare. Each flag is registered alongside the accumulator. Both flags update only while `run_en`=1 and hold their value while it is 0.
- R10: The interrupt output is 1 for exactly the one cycle after a count that produced an event. In that same cycle the accumulator and the cause bits show the event's result.
- R11: In modes 0 and 1, cause bits 1 and 3 and `lo_reached_o` read as 0. This is a mask on the outputs: the stored bits are kept and reappear when the mode returns to 2 or above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| run_en | input | 1 | Executing enable |
| cnt_en | input | 1 | Count pulse, one step per clock |
| cnt_up | input | 1 | Direction: 1 up, 0 down |
| mode | input | MODE_W | Feature mode, 0..1 basic, others full |
| lo_preset | input | W | Low preset, signed |
| hi_preset | input | W | High preset, signed |
| ovf_limit | input | W | Upper wrap limit, signed |
| unf_limit | input | W | Lower wrap limit, signed |
| wr_en | input | 1 | Cause-field write strobe |
| wr_data | input | 4 | Cause write mask, 0 clears a bit |
| acc_o | output | W | Accumulator, signed |
| lo_reached_o | output | 1 | At or below low preset |
| hi_reached_o | output | 1 | At or above high preset |
| cause_o | output | 4 | Causes: bit0 overflow, bit1 underflow, bit2 high preset, bit3 low preset |
| irq_o | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with W=8 and MODE_W=4, instead of the 32-bit default. It uses small limits (upper 6, lower -4) and presets (-2 and 3) that lie within a few steps of zero. This makes both wraps, both preset hits, the up-count-onto-low-preset non-event and the negative side of the signed compares all reachable in a few dozen cycles. Mode 5 covers the full feature set and mode 0 the basic one, including the masked cause bits returning when the mode goes back to 5.

// File: rtl/pec_pkg.sv
package pec_pkg;
    localparam int CAUSE_N = 4;
    localparam int CI_OVF  = 0;
    localparam int CI_UNF  = 1;
    localparam int CI_HI   = 2;
    localparam int CI_LO   = 3;

    typedef enum logic [2:0] {
        EV_NONE,
        EV_OVF,
        EV_UNF,
        EV_HI,
        EV_LO
    } ev_e;

    // cause pattern left behind by an event: own bit set, others cleared
    function automatic logic [CAUSE_N-1:0] ev_mask(ev_e e);
        logic [CAUSE_N-1:0] m;
        m = '0;
        case (e)
            EV_OVF:  m[CI_OVF] = 1'b1;
            EV_UNF:  m[CI_UNF] = 1'b1;
            EV_HI:   m[CI_HI]  = 1'b1;
            EV_LO:   m[CI_LO]  = 1'b1;
            default: m = '0;
        endcase
        return m;
    endfunction

    // bits visible in the basic modes
    localparam logic [CAUSE_N-1:0] BASIC_VIS = (CAUSE_N'(1) << CI_OVF) | (CAUSE_N'(1) << CI_HI);
endpackage

// File: rtl/pec_stepper.sv
module pec_stepper
    import pec_pkg::*;
#(
    parameter int W = 32
) (
    input  logic signed [W-1:0] acc,
    input  logic                step,
    input  logic                up,
    input  logic signed [W-1:0] lo_preset,
    input  logic signed [W-1:0] hi_preset,
    input  logic signed [W-1:0] ovf_limit,
    input  logic signed [W-1:0] unf_limit,
    output logic signed [W-1:0] acc_nxt,
    output ev_e                 ev
);
    localparam logic signed [W-1:0] ONE = W'(1);

    logic signed [W-1:0] inc;
    logic signed [W-1:0] dec;

    assign inc = acc + ONE;
    assign dec = acc - ONE;

    always_comb begin
        acc_nxt = acc;
        ev      = EV_NONE;
        if (step) begin
            if (up) begin
                if (acc >= ovf_limit) begin
                    acc_nxt = unf_limit;
                    ev      = EV_OVF;
                end else begin
                    acc_nxt = inc;
                    if (inc == hi_preset) ev = EV_HI;
                end
            end else begin
                if (acc <= unf_limit) begin
                    acc_nxt = ovf_limit;
                    ev      = EV_UNF;
                end else begin
                    acc_nxt = dec;
                    if (dec == lo_preset) ev = EV_LO;
                end
            end
        end
    end
endmodule

// File: rtl/pec_cause_next.sv
module pec_cause_next
    import pec_pkg::*;
(
    input  logic [CAUSE_N-1:0] cause_q,
    input  ev_e                ev,
    input  logic               wr_en,
    input  logic [CAUSE_N-1:0] wr_data,
    output logic [CAUSE_N-1:0] cause_d
);
    always_comb begin
        cause_d = cause_q;
        if (wr_en) cause_d = cause_q & wr_data;
        if (ev != EV_NONE) cause_d = ev_mask(ev);
    end
endmodule

// File: rtl/pec_reach.sv
module pec_reach #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] acc,
    input  logic signed [W-1:0] lo_preset,
    input  logic signed [W-1:0] hi_preset,
    output logic                lo_hit,
    output logic                hi_hit
);
    assign lo_hit = (acc <= lo_preset);
    assign hi_hit = (acc >= hi_preset);
endmodule

// File: rtl/pec_top.sv
module pec_top
    import pec_pkg::*;
#(
    parameter int W      = 32,
    parameter int MODE_W = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic                cnt_en,
    input  logic                cnt_up,
    input  logic [MODE_W-1:0]   mode,
    input  logic signed [W-1:0] lo_preset,
    input  logic signed [W-1:0] hi_preset,
    input  logic signed [W-1:0] ovf_limit,
    input  logic signed [W-1:0] unf_limit,
    input  logic                wr_en,
    input  logic [CAUSE_N-1:0]  wr_data,
    output logic signed [W-1:0] acc_o,
    output logic                lo_reached_o,
    output logic                hi_reached_o,
    output logic [CAUSE_N-1:0]  cause_o,
    output logic                irq_o
);
    localparam logic [MODE_W-1:0] FULL_MIN = MODE_W'(2);

    typedef struct packed {
        logic signed [W-1:0] acc;
        logic [CAUSE_N-1:0]  cause;
        logic                lo_r;
        logic                hi_r;
        logic                irq;
    } st_t;

    st_t st_d, st_q;

    logic                full;
    logic                step;
    logic                up_eff;
    logic signed [W-1:0] acc_nxt;
    ev_e                 ev;
    logic [CAUSE_N-1:0]  cause_d;
    logic                lo_hit, hi_hit;

    assign full   = (mode >= FULL_MIN);
    assign step   = run_en && cnt_en;
    assign up_eff = cnt_up || !full;

    pec_stepper #(.W(W)) u_step (
        .acc       (st_q.acc),
        .step      (step),
        .up        (up_eff),
        .lo_preset (lo_preset),
        .hi_preset (hi_preset),
        .ovf_limit (ovf_limit),
        .unf_limit (unf_limit),
        .acc_nxt   (acc_nxt),
        .ev        (ev)
    );

    pec_cause_next u_cause (
        .cause_q (st_q.cause),
        .ev      (ev),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .cause_d (cause_d)
    );

    pec_reach #(.W(W)) u_reach (
        .acc       (acc_nxt),
        .lo_preset (lo_preset),
        .hi_preset (hi_preset),
        .lo_hit    (lo_hit),
        .hi_hit    (hi_hit)
    );

    always_comb begin
        st_d       = st_q;
        st_d.irq   = 1'b0;
        st_d.cause = cause_d;
        if (run_en) begin
            st_d.acc  = acc_nxt;
            st_d.lo_r = lo_hit;
            st_d.hi_r = hi_hit;
            st_d.irq  = (ev != EV_NONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o        = st_q.acc;
    assign cause_o      = full ? st_q.cause : (st_q.cause & BASIC_VIS);
    assign lo_reached_o = st_q.lo_r && full;
    assign hi_reached_o = st_q.hi_r;
    assign irq_o        = st_q.irq;
endmodule

// File: rtl/pec_checker.sv
module pec_checker #(
    parameter int W      = 32,
    parameter int MODE_W = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                run_en,
    input logic                cnt_en,
    input logic                cnt_up,
    input logic [MODE_W-1:0]   mode,
    input logic signed [W-1:0] ovf_limit,
    input logic signed [W-1:0] unf_limit,
    input logic signed [W-1:0] acc_o,
    input logic                lo_reached_o,
    input logic [3:0]          cause_o,
    input logic                irq_o
);
    p_cause_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(cause_o));

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(run_en && cnt_en) |=> $stable(acc_o));

    p_wrap_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && cnt_en && (cnt_up || mode < MODE_W'(2)) && acc_o >= ovf_limit
        |=> acc_o == $past(unf_limit) && irq_o);

    p_wrap_dn_r4: assert property (@(posedge clk) disable iff (!rst_n)
        run_en && cnt_en && !cnt_up && mode >= MODE_W'(2) && acc_o <= unf_limit
        |=> acc_o == $past(ovf_limit) && irq_o);

    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o && $stable(mode) |-> $countones(cause_o) == 1);

    p_no_new_bits_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o && $stable(mode) |-> (cause_o & ~$past(cause_o)) == 4'b0000);

    p_basic_mask_r11: assert property (@(posedge clk) disable iff (!rst_n)
        mode < MODE_W'(2) |-> !cause_o[1] && !cause_o[3] && !lo_reached_o);
endmodule

bind pec_top pec_checker #(.W(W), .MODE_W(MODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_en       (run_en),
    .cnt_en       (cnt_en),
    .cnt_up       (cnt_up),
    .mode         (mode),
    .ovf_limit    (ovf_limit),
    .unf_limit    (unf_limit),
    .acc_o        (acc_o),
    .lo_reached_o (lo_reached_o),
    .cause_o      (cause_o),
    .irq_o        (irq_o)
);

// File: tb/pec_top_bench.sv
module pec_top_bench;
    localparam int W      = 8;
    localparam int MODE_W = 4;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                run_en = 1'b1;
    logic                cnt_en = 1'b0;
    logic                cnt_up = 1'b1;
    logic [MODE_W-1:0]   mode = 4'd5;
    logic signed [W-1:0] lo_preset = -8'sd2;
    logic signed [W-1:0] hi_preset = 8'sd3;
    logic signed [W-1:0] ovf_limit = 8'sd6;
    logic signed [W-1:0] unf_limit = -8'sd4;
    logic                wr_en = 1'b0;
    logic [3:0]          wr_data = 4'hF;
    logic signed [W-1:0] acc_o;
    logic                lo_reached_o, hi_reached_o, irq_o;
    logic [3:0]          cause_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    pec_top #(.W(W), .MODE_W(MODE_W)) u_pec_top (
        .clk (clk), .rst_n (rst_n), .run_en (run_en), .cnt_en (cnt_en),
        .cnt_up (cnt_up), .mode (mode), .lo_preset (lo_preset),
        .hi_preset (hi_preset), .ovf_limit (ovf_limit), .unf_limit (unf_limit),
        .wr_en (wr_en), .wr_data (wr_data), .acc_o (acc_o),
        .lo_reached_o (lo_reached_o), .hi_reached_o (hi_reached_o),
        .cause_o (cause_o), .irq_o (irq_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one clock with the given inputs, then results are sampled at the next negedge
    task automatic step(input bit ce, input bit up, input bit run, input bit wr, input logic [3:0] wd);
        @(negedge clk);
        cnt_en = ce; cnt_up = up; run_en = run; wr_en = wr; wr_data = wd;
        @(negedge clk);
        cnt_en = 1'b0; wr_en = 1'b0; wr_data = 4'hF; run_en = 1'b1;
    endtask

    task automatic expect_st(input string req, input int a, input int c, input int irq, input int lo, input int hi);
        chk(req, "acc", int'(acc_o), a);
        chk(req, "cause", int'(cause_o), c);
        chk(req, "irq", int'(irq_o), irq);
        chk(req, "lo_reached", int'(lo_reached_o), lo);
        chk(req, "hi_reached", int'(hi_reached_o), hi);
    endtask

    task automatic t_reset;
        #1;
        expect_st("R1", 0, 0, 0, 0, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        expect_st("R1", 0, 0, 0, 0, 0);
    endtask

    task automatic t_count_hi;
        step(1, 1, 1, 0, 4'hF); expect_st("R2", 1, 0, 0, 0, 0);
        step(1, 1, 1, 0, 4'hF); expect_st("R2", 2, 0, 0, 0, 0);
        step(1, 1, 1, 0, 4'hF); expect_st("R5", 3, 4, 1, 0, 1);
        step(0, 1, 1, 0, 4'hF); expect_st("R10", 3, 4, 0, 0, 1);
    endtask

    task automatic t_hold;
        step(1, 1, 0, 0, 4'hF); expect_st("R2", 3, 4, 0, 0, 1);
        @(negedge clk); run_en = 1'b0; hi_preset = 8'sd10;
        @(negedge clk); @(negedge clk);
        chk("R9", "hi_reached held", int'(hi_reached_o), 1);
        run_en = 1'b1;
        @(negedge clk);
        chk("R9", "hi_reached updated", int'(hi_reached_o), 0);
        hi_preset = 8'sd3;
        @(negedge clk);
    endtask

    task automatic t_ovf;
        step(1, 1, 1, 0, 4'hF); expect_st("R3", 4, 4, 0, 0, 1);
        step(1, 1, 1, 0, 4'hF);
        step(1, 1, 1, 0, 4'hF); expect_st("R3", 6, 4, 0, 0, 1);
        step(1, 1, 1, 0, 4'hF); expect_st("R7", -4, 1, 1, 1, 0);
    endtask

    task automatic t_lo;
        step(1, 1, 1, 0, 4'hF); expect_st("R9", -3, 1, 0, 1, 0);
        step(1, 1, 1, 0, 4'hF); expect_st("R6", -2, 1, 0, 1, 0);
        step(1, 1, 1, 0, 4'hF); expect_st("R9", -1, 1, 0, 0, 0);
        step(1, 0, 1, 0, 4'hF); expect_st("R6", -2, 8, 1, 1, 0);
    endtask

    task automatic t_unf;
        step(1, 0, 1, 0, 4'hF); expect_st("R2", -3, 8, 0, 1, 0);
        step(1, 0, 1, 0, 4'hF);
        step(1, 0, 1, 0, 4'hF); expect_st("R4", 6, 2, 1, 0, 1);
    endtask

    task automatic t_sw;
        step(0, 1, 1, 1, 4'b1111); chk("R8", "ones keep", int'(cause_o), 2);
        step(0, 1, 1, 1, 4'b1101); chk("R8", "zero clears", int'(cause_o), 0);
        step(1, 1, 1, 1, 4'b0000); expect_st("R8", -4, 1, 1, 1, 0);
    endtask

    task automatic t_mode;
        @(negedge clk); mode = 4'd0; #1;
        chk("R11", "ovf visible", int'(cause_o), 1);
        step(1, 0, 1, 0, 4'hF);
        chk("R2", "basic counts up", int'(acc_o), -3);
        chk("R10", "no irq", int'(irq_o), 0);
        @(negedge clk); mode = 4'd5;
        step(1, 0, 1, 0, 4'hF);
        step(1, 0, 1, 0, 4'hF); expect_st("R4", 6, 2, 1, 0, 1);
        @(negedge clk); mode = 4'd0; lo_preset = 8'sd10;
        @(negedge clk);
        chk("R11", "unf masked", int'(cause_o), 0);
        chk("R11", "lo_reached masked", int'(lo_reached_o), 0);
        mode = 4'd5; #1;
        chk("R11", "unf restored", int'(cause_o), 2);
        chk("R11", "lo_reached restored", int'(lo_reached_o), 1);
    endtask

    initial begin
        t_reset;
        t_count_hi;
        t_hold;
        t_ovf;
        t_lo;
        t_unf;
        t_sw;
        t_mode;
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule